// File: doc/BRIEF.md
# Rotate-and-Combine Byte ALU

This block is the byte-wide data path of a small controller. Each accepted instruction picks one of four operations: move, add, and, xor. The first operand comes from a register file or from an external bit-field unit. The second operand is always the auxiliary register, which is entry 0 of the register file. A 3-bit amount field in the instruction is read in one of two ways. When both ends of the instruction are registers, it is a right-rotate amount applied to the source register. When either end is an I/O field, it is a field length, and 0 stands for a full byte.

The result is registered on the clock edge. If the destination is a register, the register file is written on that same edge and a one-cycle register write strobe appears. If the destination is a field, the result is trimmed to the field length and handed to the bit-field unit with a one-cycle field write strobe. Only add changes the overflow flag, which holds the carry out of bit 7.

Top module: `rc_alu`

## Requirements
- R1: Reset (rst_n low) clears every register, including the auxiliary one, and drives result_o, dest_o, reg_we_o, field_we_o and ovf_o to 0.
- R2: When both source and destination are registers, the source is rotated right by amt (0 to 7) before the operation; for example, A5 rotated by 7 gives 4B.
- R3: Move outputs the operand unchanged, and the overflow flag keeps its value.
- R4: Add outputs the low 8 bits of operand plus auxiliary. ovf_o is set to 1 on a carry out of bit 7 and cleared to 0 without one.
- R5: And and xor combine the operand bitwise with the auxiliary register, and the overflow flag keeps its value.
- R6: With src_is_field=1, the operand is field_in masked to its low amt bits (amt=0 means all 8 bits), with no rotation.
- R7: With dst_is_field=1, the result is masked to its low amt bits and field_we_o pulses. A register source is used unrotated, add sets overflow from the unmasked sum, and no register is written.
- R8: With a register destination, the register dst_sel is written on the edge that raises reg_we_o for one cycle. dest_o shows the destination select. Writing register 0 changes the auxiliary operand for the next instruction.
- R9: While op_valid is 0, no strobe rises, and neither the registers nor the overflow flag change.
- Encoding: op_code 0=move, 1=add, 2=and, 3=xor. Outputs appear one clock after the instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| op_code | input | 2 | 0 move, 1 add, 2 and, 3 xor |
| src_is_field | input | 1 | Operand taken from field_in |
| dst_is_field | input | 1 | Result goes to the bit-field unit |
| src_sel | input | 3 | Source register index |
| dst_sel | input | 3 | Destination register or field select |
| amt | input | 3 | Rotate amount or field length (0 = 8) |
| field_in | input | 8 | Right-justified extracted field |
| result_o | output | 8 | Registered result |
| dest_o | output | 3 | Registered destination select |
| reg_we_o | output | 1 | One-cycle register write strobe |
| field_we_o | output | 1 | One-cycle field write strobe |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench goes after the places where the amt field changes meaning. A design that rotates a register source headed for a field, or fails to treat length 0 as a full byte, gives the wrong bits on vectors built to expose it. It checks that overflow is cleared by an add with no carry but left alone by move, and and xor. A sticky or always-updated flag fails those vectors. It writes register 0 and then checks that the next instruction uses the new auxiliary value, which catches a stale or separate auxiliary copy. It also reads back a register that was named only as a field destination, and a design that writes it anyway returns the wrong value.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned RC_W  = 8;
  localparam int unsigned RC_AW = $clog2(RC_W);

  typedef enum logic [1:0] {
    RC_MOVE = 2'd0,
    RC_ADD  = 2'd1,
    RC_AND  = 2'd2,
    RC_XOR  = 2'd3
  } rc_op_e;

  function automatic logic [RC_W-1:0] rot_right(input logic [RC_W-1:0] v,
                                                input logic [RC_AW-1:0] n);
    logic [2*RC_W-1:0] t;
    t = {v, v} >> n;
    return t[RC_W-1:0];
  endfunction

  function automatic logic [RC_W-1:0] len_mask(input logic [RC_AW-1:0] n);
    logic [RC_W:0] m;
    m = ({{RC_W{1'b0}}, 1'b1} << n) - 1'b1;
    return (n == '0) ? {RC_W{1'b1}} : m[RC_W-1:0];
  endfunction

  function automatic logic [RC_W:0] add_wide(input logic [RC_W-1:0] a,
                                             input logic [RC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/rc_regfile.sv
module rc_regfile
  import rc_pkg::*;
#(
  parameter int unsigned NREG = 8,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIW-1:0]  rd_idx,
  output logic [RC_W-1:0] rd_data,
  output logic [RC_W-1:0] aux_data,
  input  logic            wr_en,
  input  logic [RIW-1:0]  wr_idx,
  input  logic [RC_W-1:0] wr_data
);
  logic [RC_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (wr_idx == RIW'(g)))
        regs[g] <= wr_data;
    end
  end

  assign rd_data  = regs[rd_idx];
  assign aux_data = regs[0];
endmodule

// File: rtl/rc_operand.sv
module rc_operand
  import rc_pkg::*;
(
  input  logic             src_is_field,
  input  logic             dst_is_field,
  input  logic [RC_W-1:0]  reg_val,
  input  logic [RC_W-1:0]  field_in,
  input  logic [RC_AW-1:0] amt,
  output logic [RC_W-1:0]  operand,
  output logic [RC_W-1:0]  fmask
);
  always_comb begin
    fmask = len_mask(amt);
    if (src_is_field)
      operand = field_in & fmask;
    else if (dst_is_field)
      operand = reg_val;
    else
      operand = rot_right(reg_val, amt);
  end
endmodule

// File: rtl/rc_combine.sv
module rc_combine
  import rc_pkg::*;
(
  input  rc_op_e          op,
  input  logic [RC_W-1:0] a,
  input  logic [RC_W-1:0] aux,
  output logic [RC_W-1:0] res,
  output logic            carry,
  output logic            is_add
);
  logic [RC_W:0] sum;

  always_comb begin
    sum    = add_wide(a, aux);
    carry  = sum[RC_W];
    is_add = (op == RC_ADD);
    unique case (op)
      RC_MOVE: res = a;
      RC_ADD:  res = sum[RC_W-1:0];
      RC_AND:  res = a & aux;
      RC_XOR:  res = a ^ aux;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
#(
  parameter int unsigned NREG = 8,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic             src_is_field,
  input  logic             dst_is_field,
  input  logic [RIW-1:0]   src_sel,
  input  logic [RIW-1:0]   dst_sel,
  input  logic [RC_AW-1:0] amt,
  input  logic [RC_W-1:0]  field_in,
  output logic [RC_W-1:0]  result_o,
  output logic [RIW-1:0]   dest_o,
  output logic             reg_we_o,
  output logic             field_we_o,
  output logic             ovf_o
);
  logic [RC_W-1:0] reg_val, aux_val, operand, fmask, comb_res, out_val;
  logic            add_carry, is_add, rf_we;

  rc_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(src_sel), .rd_data(reg_val), .aux_data(aux_val),
    .wr_en(rf_we), .wr_idx(dst_sel), .wr_data(comb_res)
  );

  rc_operand u_opnd (
    .src_is_field(src_is_field), .dst_is_field(dst_is_field),
    .reg_val(reg_val), .field_in(field_in), .amt(amt),
    .operand(operand), .fmask(fmask)
  );

  rc_combine u_comb (
    .op(rc_op_e'(op_code)), .a(operand), .aux(aux_val),
    .res(comb_res), .carry(add_carry), .is_add(is_add)
  );

  assign rf_we   = op_valid && !dst_is_field;
  assign out_val = dst_is_field ? (comb_res & fmask) : comb_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o   <= '0;
      dest_o     <= '0;
      reg_we_o   <= 1'b0;
      field_we_o <= 1'b0;
      ovf_o      <= 1'b0;
    end else begin
      reg_we_o   <= rf_we;
      field_we_o <= op_valid && dst_is_field;
      if (op_valid) begin
        result_o <= out_val;
        dest_o   <= dst_sel;
        if (is_add)
          ovf_o <= add_carry;
      end
    end
  end
endmodule

// File: rtl/rc_alu_chk.sv
module rc_alu_chk
  import rc_pkg::*;
#(
  parameter int unsigned RIW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_code,
  input logic             dst_is_field,
  input logic [RIW-1:0]   dst_sel,
  input logic [RC_AW-1:0] amt,
  input logic             add_carry,
  input logic [RC_W-1:0]  result_o,
  input logic [RIW-1:0]   dest_o,
  input logic             reg_we_o,
  input logic             field_we_o,
  input logic             ovf_o
);
  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd1) |=> (ovf_o == $past(add_carry)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 2'd1) |=> $stable(ovf_o));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!reg_we_o && !field_we_o && $stable(ovf_o)));

  a_r7_field_mask: assert property (@(posedge clk) disable iff (!rst_n)
    field_we_o |-> ((result_o & ~len_mask($past(amt))) == '0));

  a_r8_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o || field_we_o) |-> (dest_o == $past(dst_sel)));

  a_r8_reg_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> $past(op_valid && !dst_is_field));
endmodule

bind rc_alu rc_alu_chk #(.RIW(RIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .dst_is_field(dst_is_field), .dst_sel(dst_sel), .amt(amt),
  .add_carry(add_carry), .result_o(result_o), .dest_o(dest_o),
  .reg_we_o(reg_we_o), .field_we_o(field_we_o), .ovf_o(ovf_o)
);

// File: tb/tb_rc_alu.sv
module tb_rc_alu;
  logic       clk = 1'b0;
  logic       rst_n, op_valid, src_is_field, dst_is_field;
  logic [1:0] op_code;
  logic [2:0] src_sel, dst_sel, amt, dest_o;
  logic [7:0] field_in, result_o;
  logic       reg_we_o, field_we_o, ovf_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rc_alu dut (.*);

  typedef struct packed {
    logic [3:0] rq;
    logic [1:0] op;
    logic       sf, df;
    logic [2:0] src, dst, am;
    logic [7:0] fld, exp;
    logic       ovf;
  } vec_t;

  // op 0 move, 1 add, 2 and, 3 xor
  localparam vec_t TBL [18] = '{
    '{4'd6, 2'd0, 1'b1, 1'b0, 3'd0, 3'd1, 3'd0, 8'hA5, 8'hA5, 1'b0}, // R6 load r1, len 0 = 8
    '{4'd8, 2'd0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 8'h0F, 8'h0F, 1'b0}, // R8 load aux
    '{4'd2, 2'd0, 1'b0, 1'b0, 3'd1, 3'd2, 3'd4, 8'h00, 8'h5A, 1'b0}, // R2 rotate 4
    '{4'd4, 2'd1, 1'b0, 1'b0, 3'd2, 3'd3, 3'd0, 8'h00, 8'h69, 1'b0}, // R4 no carry
    '{4'd4, 2'd1, 1'b1, 1'b0, 3'd0, 3'd4, 3'd0, 8'hF8, 8'h07, 1'b1}, // R4 carry
    '{4'd5, 2'd2, 1'b0, 1'b0, 3'd1, 3'd5, 3'd0, 8'h00, 8'h05, 1'b1}, // R5 and keeps ovf
    '{4'd5, 2'd3, 1'b0, 1'b0, 3'd1, 3'd5, 3'd2, 8'h00, 8'h66, 1'b1}, // R5 xor, rotate 2
    '{4'd7, 2'd0, 1'b0, 1'b1, 3'd2, 3'd3, 3'd3, 8'h00, 8'h02, 1'b1}, // R7 reg->field, no rotate
    '{4'd6, 2'd1, 1'b1, 1'b0, 3'd0, 3'd6, 3'd3, 8'hFF, 8'h16, 1'b0}, // R6 masked field, R4 clear
    '{4'd7, 2'd3, 1'b1, 1'b1, 3'd0, 3'd2, 3'd4, 8'h3C, 8'h03, 1'b0}, // R7 field->field
    '{4'd8, 2'd1, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 8'h00, 8'h1E, 1'b0}, // R8 aux += aux
    '{4'd8, 2'd2, 1'b0, 1'b0, 3'd1, 3'd7, 3'd0, 8'h00, 8'h04, 1'b0}, // R8 new aux used
    '{4'd4, 2'd1, 1'b1, 1'b0, 3'd0, 3'd7, 3'd0, 8'hE2, 8'h00, 1'b1}, // R4 sum 0x100
    '{4'd3, 2'd0, 1'b0, 1'b1, 3'd7, 3'd1, 3'd5, 8'h00, 8'h00, 1'b1}, // R3 move keeps ovf
    '{4'd7, 2'd1, 1'b1, 1'b1, 3'd0, 3'd1, 3'd2, 8'hFF, 8'h01, 1'b0}, // R7 add to field
    '{4'd7, 2'd0, 1'b0, 1'b1, 3'd3, 3'd0, 3'd0, 8'h00, 8'h69, 1'b0}, // R7 r3 untouched
    '{4'd5, 2'd0, 1'b0, 1'b1, 3'd5, 3'd0, 3'd0, 8'h00, 8'h66, 1'b0}, // R5 r5 readback
    '{4'd2, 2'd0, 1'b0, 1'b0, 3'd1, 3'd6, 3'd7, 8'h00, 8'h4B, 1'b0}  // R2 rotate 7
  };

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic sf, input logic df,
                       input logic [2:0] s, input logic [2:0] d,
                       input logic [2:0] a, input logic [7:0] f);
    op_valid = 1'b1; op_code = op; src_is_field = sf; dst_is_field = df;
    src_sel = s; dst_sel = d; amt = a; field_in = f;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; src_is_field = 1'b0;
    dst_is_field = 1'b0; src_sel = '0; dst_sel = '0; amt = '0; field_in = '0;
    repeat (3) @(negedge clk);
    chk({result_o, dest_o, reg_we_o, field_we_o, ovf_o} == '0, "R1 reset outputs",
        {result_o, dest_o, reg_we_o, field_we_o, ovf_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 18; i++) begin
      vec_t v;
      v = TBL[i];
      issue(v.op, v.sf, v.df, v.src, v.dst, v.am, v.fld);
      chk(result_o == v.exp, $sformatf("R%0d vec %0d result", v.rq, i), result_o, v.exp);
      chk(ovf_o == v.ovf, $sformatf("R%0d vec %0d ovf", v.rq, i), ovf_o, v.ovf);
      chk({reg_we_o, field_we_o, dest_o} == {!v.df, v.df, v.dst},
          $sformatf("R%0d vec %0d strobes/dest", v.rq, i),
          {reg_we_o, field_we_o, dest_o}, {!v.df, v.df, v.dst});
    end

    // R8 strobe lasts one cycle
    @(negedge clk);
    chk(!reg_we_o && !field_we_o, "R8 strobe one cycle", {reg_we_o, field_we_o}, 0);

    // R9 idle: set ovf to 1, then present an ignored add/write
    issue(2'd1, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 8'hF2); // 0xF2 + 0x1E carries, to r0
    chk(ovf_o == 1'b1, "R4 carry set", ovf_o, 1);
    op_code = 2'd1; src_is_field = 1'b1; dst_is_field = 1'b0; dst_sel = 3'd1;
    field_in = 8'h01;
    @(negedge clk);
    chk(!reg_we_o && !field_we_o, "R9 no strobe when idle", {reg_we_o, field_we_o}, 0);
    chk(ovf_o == 1'b1, "R9 ovf unchanged when idle", ovf_o, 1);
    issue(2'd0, 1'b0, 1'b1, 3'd1, 3'd0, 3'd0, 8'h00);
    chk(result_o == 8'hA5, "R9 r1 unchanged when idle", result_o, 8'hA5);
    issue(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 3'd0, 8'h00);
    chk(result_o == 8'h10, "R8 aux written r0", result_o, 8'h10);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk({result_o, dest_o, reg_we_o, field_we_o, ovf_o} == '0, "R1 reset mid-run",
        {result_o, dest_o, reg_we_o, field_we_o, ovf_o}, '0);
    rst_n = 1'b1;
    issue(2'd0, 1'b0, 1'b1, 3'd1, 3'd0, 3'd0, 8'h00);
    chk(result_o == 8'h00, "R1 r1 cleared", result_o, 0);
    issue(2'd1, 1'b1, 1'b0, 3'd0, 3'd2, 3'd0, 8'h01);
    chk(result_o == 8'h01, "R1 aux cleared", result_o, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule